// File: doc/BRIEF.md
# Read Request Completion Credit Gate

This block sits between a DMA read engine and the transmit side of a PCIe transaction layer. Before each memory read request leaves, it works out how many completion header credits and completion data credits the response could use in the worst case. It grants the request only when both amounts fit in what is left of the completion receive space. On a grant it takes that worst case off both counters and hands out a free request tag.

The gate assumes relaxed ordering is off and that the completer splits a response only at 64-byte aligned address boundaries. Every completion that arrives for an outstanding tag gives back one header credit and the data credits that this completion uses. A completion marked as the last one for its tag also frees the tag. So credits come back packet by packet, as the response drains, and not only when a whole request has finished.

The engine holds `req_valid` high together with the byte offset and length of the request. It watches `grant` in the same cycle. When `grant` is high, the request counts as issued with tag `grant_tag` at the next rising clock edge.

Top module: `rd_cpl_gate`

## Requirements
- R1: In the cycle after reset, `hdr_left` equals HDR_CREDITS, `data_left` equals DATA_CREDITS, `inflight` is 0, and `grant` stays low while `req_valid` is low.
- R2: The header cost of a request is the number of 64-byte aligned blocks touched by the byte range that starts at the offset `req_addr_lo` (6 bits, byte address modulo 64) and runs for `req_len` bytes.
- R3: The data cost of a request is the number of 16-byte aligned units touched by that same byte range. The offset used is `req_addr_lo` modulo 16.
- R4: `grant` is high in the same cycle as `req_valid` only when all of the following hold: the length is legal, a tag is free, the header cost is no more than `hdr_left`, and the data cost is no more than `data_left`. Both costs are taken off in the cycle after the grant.
- R5: A request whose length is 0 or more than 512 bytes is never granted and leaves the credits and the tags unchanged.
- R6: A completion for an outstanding tag returns 1 header credit. It also returns as data credits the number of 16-byte units touched by `cpl_len` bytes starting at `cpl_addr_lo` modulo 16. The return is visible in the next cycle.
- R7: When a grant and a returning completion fall in the same cycle, both counters apply the deduction and the return together.
- R8: `grant_tag` is the lowest-numbered free tag. A completion with `cpl_last` high frees its tag, and that tag can be granted again from the next cycle.
- R9: `inflight` equals the number of tags that are outstanding. No grant is given while all NUM_TAGS tags are outstanding.
- R10: A completion whose tag is not outstanding changes neither the credits nor the tags.
- R11: With the default 28 header credits and 112 data credits, three 512-byte requests aligned to 64 bytes are granted and a fourth is refused until credits come back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Engine presents a read request |
| req_addr_lo | input | 6 | Request start address modulo 64 |
| req_len | input | 10 | Request length in bytes |
| grant | output | 1 | Request admitted this cycle |
| grant_tag | output | TAG_W (3) | Tag for the admitted request |
| cpl_valid | input | 1 | A completion has arrived |
| cpl_tag | input | TAG_W (3) | Tag carried by the completion |
| cpl_addr_lo | input | 6 | Lower byte address of the completion payload |
| cpl_len | input | 10 | Completion payload length in bytes |
| cpl_last | input | 1 | Final completion for this tag |
| inflight | output | CNT_W (4) | Number of outstanding requests |
| hdr_left | output | 8 | Remaining completion header credits |
| data_left | output | 8 | Remaining completion data credits |

## Verification
The hardest case to reach from the ports is a grant and a credit return in the very same cycle, because it needs a request already outstanding and two unrelated input streams lined up on one edge. The bench first issues a request and then drives a partial completion for that tag while a second request is presented in the same cycle. It chooses a second request whose cost differs from the amount returned, so the net change shows whether each update was applied or lost. It also reaches the empty tag pool by issuing one-block requests that are too cheap to run out of credits first.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int MAX_REQ_BYTES = 512;
    localparam int RCB_SHIFT     = 6;
    localparam int UNIT_SHIFT    = 4;
    localparam int LEN_W         = $clog2(MAX_REQ_BYTES + 1);
    localparam int OFS_W         = RCB_SHIFT;
    localparam int CRED_W        = 8;
    localparam int SUM_W         = LEN_W + 2;

    typedef struct packed {
        logic [CRED_W-1:0] hdr;
        logic [CRED_W-1:0] dat;
    } cost_t;

    // Count the aligned units of size 2**shift that a byte range touches.
    function automatic logic [CRED_W-1:0] units_touched(
        input logic [OFS_W-1:0] ofs,
        input logic [LEN_W-1:0] len,
        input int               shift
    );
        logic [SUM_W-1:0] s;
        s = SUM_W'(ofs) + SUM_W'(len) + SUM_W'((1 << shift) - 1);
        return CRED_W'(s >> shift);
    endfunction
endpackage

// File: rtl/rcg_span.sv
module rcg_span
    import rcg_pkg::*;
#(
    parameter int SHIFT = UNIT_SHIFT
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [LEN_W-1:0]  len,
    output logic [CRED_W-1:0] units
);
    localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'((1 << SHIFT) - 1);

    logic [OFS_W-1:0] ofs_m;

    always_comb begin
        ofs_m = ofs & OFS_MASK;
        units = units_touched(ofs_m, len, SHIFT);
    end
endmodule

// File: rtl/rcg_credit_ctr.sv
module rcg_credit_ctr #(
    parameter int W    = 8,
    parameter int INIT = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take_en,
    input  logic [W-1:0] take_amt,
    input  logic         give_en,
    input  logic [W-1:0] give_amt,
    output logic [W-1:0] level
);
    logic [W:0] nxt;

    always_comb begin
        nxt = {1'b0, level};
        if (take_en) nxt = nxt - {1'b0, take_amt};
        if (give_en) nxt = nxt + {1'b0, give_amt};
    end

    always_ff @(posedge clk) begin
        if (rst) level <= W'(INIT);
        else     level <= nxt[W-1:0];
    end
endmodule

// File: rtl/rcg_tag_pool.sv
module rcg_tag_pool #(
    parameter int N  = 8,
    parameter int TW = $clog2(N),
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic          rel_en,
    input  logic [TW-1:0] rel_tag,
    output logic          any_free,
    output logic [TW-1:0] free_tag,
    output logic [N-1:0]  busy,
    output logic [CW-1:0] count
);
    always_comb begin
        any_free = 1'b0;
        free_tag = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_tag = TW'(i);
            end
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) count = count + CW'(busy[i]);
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                busy[g] <= 1'b0;
            else if (alloc && free_tag == TW'(g))
                busy[g] <= 1'b1;
            else if (rel_en && rel_tag == TW'(g))
                busy[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rd_cpl_gate.sv
module rd_cpl_gate
    import rcg_pkg::*;
#(
    parameter int NUM_TAGS     = 8,
    parameter int HDR_CREDITS  = 28,
    parameter int DATA_CREDITS = 112,
    parameter int TAG_W        = $clog2(NUM_TAGS),
    parameter int CNT_W        = $clog2(NUM_TAGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [OFS_W-1:0]  req_addr_lo,
    input  logic [LEN_W-1:0]  req_len,
    output logic              grant,
    output logic [TAG_W-1:0]  grant_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [OFS_W-1:0]  cpl_addr_lo,
    input  logic [LEN_W-1:0]  cpl_len,
    input  logic              cpl_last,
    output logic [CNT_W-1:0]  inflight,
    output logic [CRED_W-1:0] hdr_left,
    output logic [CRED_W-1:0] data_left
);
    cost_t                req_cost;
    logic [CRED_W-1:0]    cpl_dat;
    logic                 len_ok;
    logic                 any_free;
    logic [NUM_TAGS-1:0]  busy;
    logic                 cpl_hit;

    rcg_span #(.SHIFT(RCB_SHIFT)) u_req_hdr (
        .ofs(req_addr_lo), .len(req_len), .units(req_cost.hdr)
    );
    rcg_span #(.SHIFT(UNIT_SHIFT)) u_req_dat (
        .ofs(req_addr_lo), .len(req_len), .units(req_cost.dat)
    );
    rcg_span #(.SHIFT(UNIT_SHIFT)) u_cpl_dat (
        .ofs(cpl_addr_lo), .len(cpl_len), .units(cpl_dat)
    );

    always_comb begin
        len_ok  = (req_len != '0) && (req_len <= LEN_W'(MAX_REQ_BYTES));
        cpl_hit = cpl_valid && busy[cpl_tag];
        grant   = req_valid && len_ok && any_free &&
                  (req_cost.hdr <= hdr_left) && (req_cost.dat <= data_left);
    end

    rcg_tag_pool #(.N(NUM_TAGS), .TW(TAG_W), .CW(CNT_W)) u_tags (
        .clk(clk), .rst(rst),
        .alloc(grant),
        .rel_en(cpl_hit && cpl_last), .rel_tag(cpl_tag),
        .any_free(any_free), .free_tag(grant_tag),
        .busy(busy), .count(inflight)
    );

    rcg_credit_ctr #(.W(CRED_W), .INIT(HDR_CREDITS)) u_hdr_ctr (
        .clk(clk), .rst(rst),
        .take_en(grant), .take_amt(req_cost.hdr),
        .give_en(cpl_hit), .give_amt(CRED_W'(1)),
        .level(hdr_left)
    );

    rcg_credit_ctr #(.W(CRED_W), .INIT(DATA_CREDITS)) u_dat_ctr (
        .clk(clk), .rst(rst),
        .take_en(grant), .take_amt(req_cost.dat),
        .give_en(cpl_hit), .give_amt(cpl_dat),
        .level(data_left)
    );
endmodule

// File: rtl/rd_cpl_gate_chk.sv
module rd_cpl_gate_chk
    import rcg_pkg::*;
#(
    parameter int NUM_TAGS     = 8,
    parameter int HDR_CREDITS  = 28,
    parameter int DATA_CREDITS = 112,
    parameter int CNT_W        = $clog2(NUM_TAGS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [LEN_W-1:0]  req_len,
    input logic              grant,
    input logic              cpl_valid,
    input logic [CNT_W-1:0]  inflight,
    input logic [CRED_W-1:0] hdr_left,
    input logic [CRED_W-1:0] data_left
);
    // R1
    reset_levels_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hdr_left == CRED_W'(HDR_CREDITS)) &&
                       (data_left == CRED_W'(DATA_CREDITS)) && (inflight == '0));

    // R4
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> req_valid);

    // R5
    bad_len_chk: assert property (@(posedge clk) disable iff (rst)
        (req_len == '0 || req_len > LEN_W'(MAX_REQ_BYTES)) |-> !grant);

    // R9
    pool_full_chk: assert property (@(posedge clk) disable iff (rst)
        (inflight == CNT_W'(NUM_TAGS)) |-> !grant);

    // R9
    inflight_step_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && !cpl_valid) |=> inflight == $past(inflight) + CNT_W'(1));

    // R6
    credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_left <= CRED_W'(HDR_CREDITS)) && (data_left <= CRED_W'(DATA_CREDITS)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant && !cpl_valid) |=> $stable(hdr_left) && $stable(data_left));
endmodule

bind rd_cpl_gate rd_cpl_gate_chk #(
    .NUM_TAGS(NUM_TAGS), .HDR_CREDITS(HDR_CREDITS), .DATA_CREDITS(DATA_CREDITS)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
    .grant(grant), .cpl_valid(cpl_valid), .inflight(inflight),
    .hdr_left(hdr_left), .data_left(data_left)
);

// File: tb/rd_cpl_gate_tb.sv
module rd_cpl_gate_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [5:0] req_addr_lo = '0;
    logic [9:0] req_len = '0;
    logic       grant;
    logic [2:0] grant_tag;
    logic       cpl_valid = 1'b0;
    logic [2:0] cpl_tag = '0;
    logic [5:0] cpl_addr_lo = '0;
    logic [9:0] cpl_len = '0;
    logic       cpl_last = 1'b0;
    logic [3:0] inflight;
    logic [7:0] hdr_left;
    logic [7:0] data_left;

    int n_chk = 0;
    int n_bad = 0;
    int exp_h = 28;
    int exp_d = 112;
    bit bsy [8];

    always #4 clk = ~clk;

    rd_cpl_gate u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr_lo(req_addr_lo),
        .req_len(req_len), .grant(grant), .grant_tag(grant_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_addr_lo(cpl_addr_lo),
        .cpl_len(cpl_len), .cpl_last(cpl_last), .inflight(inflight),
        .hdr_left(hdr_left), .data_left(data_left)
    );

    function automatic int hcost(int a, int l);
        return ((a % 64) + l + 63) / 64;
    endfunction
    function automatic int dcost(int a, int l);
        return ((a % 16) + l + 15) / 16;
    endfunction
    function automatic int busy_cnt();
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(bsy[i]);
        return c;
    endfunction

    task automatic chk(input string r, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic chk_state(input string r);
        chk(r, "hdr_left", int'(hdr_left), exp_h);
        chk(r, "data_left", int'(data_left), exp_d);
        chk(r, "inflight", int'(inflight), busy_cnt());
    endtask

    task automatic drive_req(input int a, input int l);
        req_valid = 1'b1; req_addr_lo = 6'(a); req_len = 10'(l);
    endtask

    task automatic drive_cpl(input int t, input int a, input int l, input bit last);
        cpl_valid = 1'b1; cpl_tag = 3'(t); cpl_addr_lo = 6'(a);
        cpl_len = 10'(l); cpl_last = last;
    endtask

    task automatic model_cpl(input int t, input int a, input int l, input bit last);
        if (bsy[t]) begin
            exp_h += 1;
            exp_d += dcost(a, l);
            if (last) bsy[t] = 1'b0;
        end
    endtask

    task automatic do_req(input int a, input int l, input bit eg, input int et, input string r);
        @(negedge clk);
        drive_req(a, l);
        #1;
        chk(r, "grant", int'(grant), int'(eg));
        if (eg) begin
            chk(r, "grant_tag", int'(grant_tag), et);
            exp_h -= hcost(a, l);
            exp_d -= dcost(a, l);
            bsy[et] = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk_state(r);
    endtask

    task automatic do_cpl(input int t, input int a, input int l, input bit last, input string r);
        @(negedge clk);
        drive_cpl(t, a, l, last);
        model_cpl(t, a, l, last);
        @(negedge clk);
        cpl_valid = 1'b0;
        chk_state(r);
    endtask

    task automatic t_reset();
        chk("R1", "grant", int'(grant), 0);
        chk_state("R1");
    endtask

    task automatic t_max_requests();
        for (int i = 0; i < 3; i++) do_req(0, 512, 1'b1, i, "R11");
        do_req(0, 512, 1'b0, 0, "R11");
        for (int t = 0; t < 3; t++)
            for (int k = 0; k < 8; k++) do_cpl(t, 0, 64, k == 7, "R6");
        do_req(0, 512, 1'b1, 0, "R4");
        for (int k = 0; k < 8; k++) do_cpl(0, 0, 64, k == 7, "R6");
    endtask

    task automatic t_unaligned();
        do_req(60, 8, 1'b1, 0, "R2");
        do_cpl(0, 60, 4, 1'b0, "R6");
        do_cpl(0, 0, 4, 1'b1, "R6");
        do_req(5, 100, 1'b1, 0, "R3");
        do_cpl(0, 5, 59, 1'b0, "R6");
        do_cpl(0, 0, 41, 1'b1, "R6");
    endtask

    task automatic t_bad_len();
        do_req(0, 0, 1'b0, 0, "R5");
        do_req(0, 513, 1'b0, 0, "R5");
    endtask

    task automatic t_tag_pool();
        for (int i = 0; i < 8; i++) do_req(0, 64, 1'b1, i, "R8");
        do_req(0, 64, 1'b0, 0, "R9");
        do_cpl(3, 0, 64, 1'b1, "R8");
        do_req(0, 64, 1'b1, 3, "R8");
        for (int t = 0; t < 8; t++) do_cpl(t, 0, 64, 1'b1, "R9");
    endtask

    task automatic t_stray();
        do_cpl(5, 0, 64, 1'b1, "R10");
        do_cpl(2, 8, 32, 1'b0, "R10");
    endtask

    task automatic t_same_cycle();
        do_req(0, 128, 1'b1, 0, "R7");
        @(negedge clk);
        drive_req(0, 128);
        drive_cpl(0, 0, 64, 1'b0);
        #1;
        chk("R7", "grant", int'(grant), 1);
        chk("R7", "grant_tag", int'(grant_tag), 1);
        exp_h -= hcost(0, 128);
        exp_d -= dcost(0, 128);
        bsy[1] = 1'b1;
        model_cpl(0, 0, 64, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        cpl_valid = 1'b0;
        chk_state("R7");
        do_cpl(0, 0, 64, 1'b1, "R7");
        do_cpl(1, 0, 64, 1'b0, "R7");
        do_cpl(1, 0, 64, 1'b1, "R7");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_max_requests();
        t_unaligned();
        t_bad_len();
        t_tag_pool();
        t_stray();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule